// File: doc/BRIEF.md
# Platform System I/O Register Block

This block sits on a byte-wide I/O-port bus of a workstation-class system board. It decodes a fixed set of port addresses. It holds three small control registers, and each one accepts only its own defined bits on a write. Reads of the identification ports return board strap values. Two sideband outputs come straight from stored register bits. One is a soft-reset request to the processor reset logic. The other selects the non-contiguous I/O-map mode, and it comes out of reset asserted.

Register bits use reversed numbering: bit n of a register carries weight 1 << (7 - n). Bit 0 is therefore the most significant bit and bit 7 the least. Several ports are write-only. Writes to them complete and change nothing. A separate 32-bit status window answers full-word reads only.

Top module: `sysio_ctrl`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `io_rdata` is 0x00, `soft_reset_o` is 0, `iomap_nc_o` is 1, `le_err_o` is 0, `win_ack` is 0 and `win_rdata` is 0.
- R2: A write to port 0x092 stores only the soft-reset bit (bit 7, weight 0x01). `soft_reset_o` equals that stored bit from the cycle after the write. A read of 0x092 returns the stored value.
- R3: A write to port 0x092 with the little-endian bit (bit 6, weight 0x02) set is not stored, and it sets `le_err_o`. `le_err_o` stays set until reset.
- R4: Port 0x81C (system control) keeps only bits 0 to 3 (mask 0xF0) of a write. A read returns the masked stored value. The register resets to 0.
- R5: Port 0x850 (I/O map type) keeps only bit 7 (weight 0x01). That bit drives `iomap_nc_o`, and a read returns it. It resets to 0x01.
- R6: Port 0x80C returns `strap_equip` and port 0x852 returns `strap_board`. Writes to these two ports change no register and no output.
- R7: Ports 0x808, 0x810, 0x812 and 0x814 are write-only. Writes to them change no register and no output, and reads of them return 0xFF.
- R8: A read of port 0x818 (keylock) returns 0x00.
- R9: A read of any address that is not decoded returns 0xFF. A write to it has no effect.
- R10: A window read with all four byte enables (`win_be` = 4'hF) raises `win_ack` in the next cycle, with `win_rdata` = 0x00000000. A window read with any other `win_be` value gets no acknowledge.
- R11: Read data appears on `io_rdata` in the cycle after the read strobe. It holds its value through every cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_sel | input | 1 | Port access strobe, one cycle per access |
| io_wr | input | 1 | 1 = write, 0 = read, qualified by io_sel |
| io_addr | input | 12 | Port address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| strap_equip | input | 8 | Equipment strap value |
| strap_board | input | 8 | Board identification strap value |
| win_rd | input | 1 | Status window read strobe |
| win_be | input | 4 | Status window byte enables |
| win_rdata | output | 32 | Status window read data |
| win_ack | output | 1 | Status window read acknowledge |
| soft_reset_o | output | 1 | Soft-reset request |
| iomap_nc_o | output | 1 | Non-contiguous I/O-map mode select |
| le_err_o | output | 1 | Sticky flag for an unsupported little-endian request |

## Verification
Every result is due exactly one clock edge after its stimulus. Register writes reach the sideband outputs and `le_err_o` at that edge. Port reads reach `io_rdata` at that edge, and window reads reach `win_ack` and `win_rdata` at that edge. The bench drives each access on a falling edge. At the next rising edge a behavioural reference model updates from the same inputs, and on the following falling edge every output is compared with the model. This matches the one-edge latency. It also covers the hold behaviour of `io_rdata` in idle cycles.

// File: rtl/sysio_pkg.sv
package sysio_pkg;

    parameter int ADDR_W = 12;
    parameter int DATA_W = 8;
    parameter int WIN_W  = 32;

    // reversed bit numbering: index n has weight 1 << (7 - n)
    function automatic logic [DATA_W-1:0] rbit(input int n);
        logic [DATA_W-1:0] v;
        v = '0;
        v[DATA_W-1-n] = 1'b1;
        return v;
    endfunction

    localparam logic [DATA_W-1:0] SRST_BIT   = rbit(7);
    localparam logic [DATA_W-1:0] LE_BIT     = rbit(6);
    localparam logic [DATA_W-1:0] SYSCTL_MSK = rbit(0) | rbit(1) | rbit(2) | rbit(3);
    localparam logic [DATA_W-1:0] IOMAP_BIT  = rbit(7);
    localparam logic [DATA_W-1:0] IOMAP_RST  = IOMAP_BIT;
    localparam logic [DATA_W-1:0] NOPORT_VAL = '1;
    localparam logic [DATA_W-1:0] KEYLK_VAL  = '0;

    localparam logic [ADDR_W-1:0] A_RESET   = 12'h092;
    localparam logic [ADDR_W-1:0] A_LIGHT   = 12'h808;
    localparam logic [ADDR_W-1:0] A_EQUIP   = 12'h80C;
    localparam logic [ADDR_W-1:0] A_PASS1   = 12'h810;
    localparam logic [ADDR_W-1:0] A_PASS2   = 12'h812;
    localparam logic [ADDR_W-1:0] A_CINV    = 12'h814;
    localparam logic [ADDR_W-1:0] A_KEYLK   = 12'h818;
    localparam logic [ADDR_W-1:0] A_SYSCTL  = 12'h81C;
    localparam logic [ADDR_W-1:0] A_IOMAP   = 12'h850;
    localparam logic [ADDR_W-1:0] A_BOARD   = 12'h852;

    typedef enum logic [3:0] {
        PT_NONE,
        PT_RESET,
        PT_WONLY,
        PT_EQUIP,
        PT_KEYLK,
        PT_SYSCTL,
        PT_IOMAP,
        PT_BOARD
    } port_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        port_e             port;
        logic [DATA_W-1:0] data;
    } access_t;

    typedef struct packed {
        logic [DATA_W-1:0] rst_reg;
        logic [DATA_W-1:0] sysctl;
        logic [DATA_W-1:0] iomap;
    } regs_t;

    function automatic port_e decode(input logic [ADDR_W-1:0] a);
        port_e p;
        unique case (a)
            A_RESET:  p = PT_RESET;
            A_LIGHT,
            A_PASS1,
            A_PASS2,
            A_CINV:   p = PT_WONLY;
            A_EQUIP:  p = PT_EQUIP;
            A_KEYLK:  p = PT_KEYLK;
            A_SYSCTL: p = PT_SYSCTL;
            A_IOMAP:  p = PT_IOMAP;
            A_BOARD:  p = PT_BOARD;
            default:  p = PT_NONE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sysio_decode.sv
module sysio_decode
    import sysio_pkg::*;
(
    input  logic              io_sel,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    output access_t           acc
);
    always_comb begin
        acc.rd   = io_sel && !io_wr;
        acc.wr   = io_sel && io_wr;
        acc.port = decode(io_addr);
        acc.data = io_wdata;
    end
endmodule

// File: rtl/sysio_regs.sv
module sysio_regs
    import sysio_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  access_t acc,
    output regs_t   regs,
    output logic    le_err
);
    logic wr_reset, wr_sysctl, wr_iomap;

    always_comb begin
        wr_reset  = acc.wr && (acc.port == PT_RESET);
        wr_sysctl = acc.wr && (acc.port == PT_SYSCTL);
        wr_iomap  = acc.wr && (acc.port == PT_IOMAP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs.rst_reg <= '0;
            regs.sysctl  <= '0;
            regs.iomap   <= IOMAP_RST;
            le_err       <= 1'b0;
        end else begin
            if (wr_reset) begin
                regs.rst_reg <= acc.data & SRST_BIT;
                if ((acc.data & LE_BIT) != '0)
                    le_err <= 1'b1;
            end
            if (wr_sysctl)
                regs.sysctl <= acc.data & SYSCTL_MSK;
            if (wr_iomap)
                regs.iomap <= acc.data & IOMAP_BIT;
        end
    end

    AST_LE_SET: assert property (@(posedge clk) disable iff (rst)
        (wr_reset && ((acc.data & LE_BIT) != '0)) |=> le_err); // R3
    AST_LE_STICKY: assert property (@(posedge clk) disable iff (rst)
        le_err |=> le_err); // R3
    AST_LE_NOT_STORED: assert property (@(posedge clk) disable iff (rst)
        wr_reset |=> ((regs.rst_reg & LE_BIT) == '0)); // R3
    AST_SYSCTL_KEEP: assert property (@(posedge clk) disable iff (rst)
        !wr_sysctl |=> $stable(regs.sysctl)); // R4
endmodule

// File: rtl/sysio_rdmux.sv
module sysio_rdmux
    import sysio_pkg::*;
#(
    parameter logic [WIN_W-1:0] STATUS_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  access_t           acc,
    input  regs_t             regs,
    input  logic [DATA_W-1:0] strap_equip,
    input  logic [DATA_W-1:0] strap_board,
    input  logic              win_rd,
    input  logic [3:0]        win_be,
    output logic [DATA_W-1:0] io_rdata,
    output logic [WIN_W-1:0]  win_rdata,
    output logic              win_ack
);
    logic [DATA_W-1:0] rsel;
    logic              win_full;

    always_comb begin
        unique case (acc.port)
            PT_RESET:  rsel = regs.rst_reg;
            PT_EQUIP:  rsel = strap_equip;
            PT_KEYLK:  rsel = KEYLK_VAL;
            PT_SYSCTL: rsel = regs.sysctl;
            PT_IOMAP:  rsel = regs.iomap;
            PT_BOARD:  rsel = strap_board;
            default:   rsel = NOPORT_VAL;
        endcase
        win_full = win_rd && (win_be == 4'hF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            io_rdata  <= '0;
            win_rdata <= '0;
            win_ack   <= 1'b0;
        end else begin
            if (acc.rd)
                io_rdata <= rsel;
            win_ack <= win_full;
            if (win_full)
                win_rdata <= STATUS_VAL;
        end
    end

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !acc.rd |=> $stable(io_rdata)); // R11
    AST_WIN_PARTIAL: assert property (@(posedge clk) disable iff (rst)
        (win_rd && win_be != 4'hF) |=> !win_ack); // R10
    AST_WIN_NOREQ: assert property (@(posedge clk) disable iff (rst)
        !win_rd |=> !win_ack); // R10
endmodule

// File: rtl/sysio_ctrl.sv
module sysio_ctrl
    import sysio_pkg::*;
#(
    parameter logic [WIN_W-1:0] STATUS_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_sel,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    input  logic [DATA_W-1:0] strap_equip,
    input  logic [DATA_W-1:0] strap_board,
    input  logic              win_rd,
    input  logic [3:0]        win_be,
    output logic [WIN_W-1:0]  win_rdata,
    output logic              win_ack,
    output logic              soft_reset_o,
    output logic              iomap_nc_o,
    output logic              le_err_o
);
    access_t acc;
    regs_t   regs;
    logic    le_err;

    sysio_decode u_dec (
        .io_sel   (io_sel),
        .io_wr    (io_wr),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .acc      (acc)
    );

    sysio_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .acc    (acc),
        .regs   (regs),
        .le_err (le_err)
    );

    sysio_rdmux #(.STATUS_VAL(STATUS_VAL)) u_rd (
        .clk         (clk),
        .rst         (rst),
        .acc         (acc),
        .regs        (regs),
        .strap_equip (strap_equip),
        .strap_board (strap_board),
        .win_rd      (win_rd),
        .win_be      (win_be),
        .io_rdata    (io_rdata),
        .win_rdata   (win_rdata),
        .win_ack     (win_ack)
    );

    assign soft_reset_o = (regs.rst_reg & SRST_BIT) != '0;
    assign iomap_nc_o   = (regs.iomap & IOMAP_BIT) != '0;
    assign le_err_o     = le_err;

    AST_SRST_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (io_sel && io_wr && io_addr == A_RESET) |=> (soft_reset_o == $past(io_wdata[0]))); // R2
    AST_IOMAP_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (io_sel && io_wr && io_addr == A_IOMAP) |=> (iomap_nc_o == $past(io_wdata[0]))); // R5
    AST_SYSCTL_RDMASK: assert property (@(posedge clk) disable iff (rst)
        (io_sel && !io_wr && io_addr == A_SYSCTL) |=> (io_rdata[3:0] == 4'h0)); // R4
    AST_KEYLK_ZERO: assert property (@(posedge clk) disable iff (rst)
        (io_sel && !io_wr && io_addr == A_KEYLK) |=> (io_rdata == 8'h00)); // R8
    AST_RST_IOMAP: assert property (@(posedge clk)
        rst |=> (iomap_nc_o && !soft_reset_o && !le_err_o)); // R1
endmodule

// File: tb/tb_sysio_ctrl.sv
module tb_sysio_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        io_sel, io_wr;
    logic [11:0] io_addr;
    logic [7:0]  io_wdata;
    logic [7:0]  io_rdata;
    logic [7:0]  strap_equip, strap_board;
    logic        win_rd;
    logic [3:0]  win_be;
    logic [31:0] win_rdata;
    logic        win_ack;
    logic        soft_reset_o, iomap_nc_o, le_err_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference model state
    logic [7:0]  m_rst, m_sys, m_map, m_rdata;
    logic        m_err, m_ack;
    logic [31:0] m_win;
    string       tag = "R1";
    string       m_tag = "R1";

    sysio_ctrl dut (.*);

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        m_tag = tag;
        if (rst) begin
            m_rst = 8'h00; m_sys = 8'h00; m_map = 8'h01; m_err = 1'b0;
            m_rdata = 8'h00; m_ack = 1'b0; m_win = 32'h0;
        end else begin
            if (io_sel && io_wr) begin
                if (io_addr == 12'h092) begin
                    m_rst = io_wdata & 8'h01;
                    if (io_wdata[1]) m_err = 1'b1;
                end else if (io_addr == 12'h81C) m_sys = io_wdata & 8'hF0;
                else if (io_addr == 12'h850) m_map = io_wdata & 8'h01;
            end else if (io_sel) begin
                case (io_addr)
                    12'h092: m_rdata = m_rst;
                    12'h80C: m_rdata = strap_equip;
                    12'h818: m_rdata = 8'h00;
                    12'h81C: m_rdata = m_sys;
                    12'h850: m_rdata = m_map;
                    12'h852: m_rdata = strap_board;
                    default: m_rdata = 8'hFF;
                endcase
            end
            m_ack = win_rd && (win_be == 4'hF);
            if (m_ack) m_win = 32'h0;
        end
    end

    task automatic cmp(string name, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", m_tag, name, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cycles > 0) begin
            cmp("io_rdata", 32'(io_rdata), 32'(m_rdata));
            cmp("soft_reset_o", 32'(soft_reset_o), 32'(m_rst[0]));
            cmp("iomap_nc_o", 32'(iomap_nc_o), 32'(m_map[0]));
            cmp("le_err_o", 32'(le_err_o), 32'(m_err));
            cmp("win_ack", 32'(win_ack), 32'(m_ack));
            cmp("win_rdata", win_rdata, m_win);
        end
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic idle();
        @(negedge clk);
        io_sel = 0; io_wr = 0; win_rd = 0; win_be = 4'h0;
    endtask

    task automatic wr(string t, logic [11:0] a, logic [7:0] d);
        @(negedge clk);
        tag = t; io_sel = 1; io_wr = 1; io_addr = a; io_wdata = d; win_rd = 0;
    endtask

    task automatic rd(string t, logic [11:0] a);
        @(negedge clk);
        tag = t; io_sel = 1; io_wr = 0; io_addr = a; io_wdata = 8'h5A; win_rd = 0;
    endtask

    task automatic wrd(string t, logic [3:0] be);
        @(negedge clk);
        tag = t; io_sel = 0; win_rd = 1; win_be = be;
    endtask

    initial begin
        rst = 1; io_sel = 0; io_wr = 0; io_addr = 0; io_wdata = 0;
        win_rd = 0; win_be = 0; strap_equip = 8'hA5; strap_board = 8'h3C;
        repeat (3) @(negedge clk);
        tag = "R1"; rst = 0;
        idle(); idle();
        // R1 reset values on the I/O map register
        rd("R1", 12'h850); rd("R1", 12'h092); rd("R1", 12'h81C);
        // R2 soft reset bit, other bits dropped
        wr("R2", 12'h092, 8'h01); rd("R2", 12'h092);
        wr("R2", 12'h092, 8'hFC); rd("R2", 12'h092);
        wr("R2", 12'h092, 8'h81); rd("R2", 12'h092);
        // R3 little-endian request sets sticky error, not stored
        wr("R3", 12'h092, 8'h02); rd("R3", 12'h092);
        wr("R3", 12'h092, 8'h00); idle(); rd("R3", 12'h092);
        // R4 system control mask
        wr("R4", 12'h81C, 8'hFF); rd("R4", 12'h81C);
        wr("R4", 12'h81C, 8'h5A); rd("R4", 12'h81C);
        wr("R4", 12'h81C, 8'h0F); rd("R4", 12'h81C);
        wr("R4", 12'h81C, 8'hA0);
        // R5 I/O map bit
        wr("R5", 12'h850, 8'h00); rd("R5", 12'h850);
        wr("R5", 12'h850, 8'hFE); rd("R5", 12'h850);
        wr("R5", 12'h850, 8'hFF); rd("R5", 12'h850);
        wr("R5", 12'h850, 8'h80);
        // R6 straps, writes ignored
        rd("R6", 12'h80C); rd("R6", 12'h852);
        wr("R6", 12'h80C, 8'h00); wr("R6", 12'h852, 8'hFF);
        rd("R6", 12'h80C); rd("R6", 12'h852);
        strap_equip = 8'h11; strap_board = 8'hE7;
        rd("R6", 12'h80C); rd("R6", 12'h852);
        // R7 write-only ports
        wr("R2", 12'h092, 8'h01); wr("R5", 12'h850, 8'h01);
        wr("R7", 12'h808, 8'hFF); wr("R7", 12'h810, 8'h00);
        wr("R7", 12'h812, 8'hFF); wr("R7", 12'h814, 8'h00);
        rd("R7", 12'h808); rd("R7", 12'h810); rd("R7", 12'h812); rd("R7", 12'h814);
        rd("R7", 12'h092); rd("R7", 12'h81C); rd("R7", 12'h850);
        // R8 keylock
        rd("R8", 12'h818); wr("R8", 12'h818, 8'hFF); rd("R8", 12'h818);
        // R9 unmapped
        rd("R9", 12'h000); rd("R9", 12'h093); rd("R9", 12'hFFF);
        wr("R9", 12'h091, 8'hFF); rd("R9", 12'h092);
        // R10 status window
        wrd("R10", 4'hF); wrd("R10", 4'h7); wrd("R10", 4'h1);
        wrd("R10", 4'hF); wrd("R10", 4'h0); idle();
        // R11 hold across idle cycles
        rd("R11", 12'h80C); idle(); idle(); idle();
        wr("R11", 12'h81C, 8'h30); idle(); rd("R11", 12'h81C); idle(); idle();
        // R1 reset again clears error and registers
        @(negedge clk); tag = "R1"; rst = 1; io_sel = 0;
        @(negedge clk); rst = 0;
        idle(); rd("R1", 12'h850); rd("R1", 12'h81C); idle(); idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule